// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between one bus master and a 32-bit, word-addressed memory or register target. It gives the master a way to reach single bits of target words. It watches each request for an address that falls inside one of two alias windows. In each window, one 32-bit alias word stands for exactly one bit of one target word. One window is mapped onto a RAM region and the other onto a peripheral region. Each window has its own target base, its own alias base and its own span.

An alias read fetches the target word and returns only the selected bit, in result bit 0. An alias write is turned into a read-modify-write of the target word that replaces only the selected bit. A lock signal keeps other agents away from the word while the read-modify-write is in progress. The master sees one transaction, and its ready stays low until the final target write completes. A request outside both windows goes to the target unchanged, as a single transaction.

Software uses the alias windows to flip a flag or a control bit without a read-modify-write sequence of its own. It also uses them to test a bit without masking in code.

Top module: `bitband_bridge`

## Requirements
- R1: For an alias address A in a window with alias base AB and target base TB, let the offset be O = A - AB. The target word is at TB + 4*floor(O/128), and the bit index is O[6:2]. The alias address bits [1:0] are ignored.
- R2: An alias read issues one unlocked target read of the mapped word. It returns the selected bit in m_rdata[0], and m_rdata[31:1] is zero.
- R3: An alias write sets the selected target bit to m_wdata[0]. The bits m_wdata[31:1] have no effect on the target.
- R4: An alias write leaves every other bit of the addressed word, and every other target word, unchanged.
- R5: An alias write produces exactly two target handshakes on consecutive transactions: a read of the mapped word, then a write to the same word. No other target access comes between them.
- R6: t_lock is high from the start of the read request of an alias write until the cycle in which its write is accepted. It is low at all other times, and it is only ever high together with t_valid.
- R7: m_ready is high for exactly one cycle per master request. That cycle is the one in which the last target handshake of the request completes. In particular, m_ready stays low across the read phase of a read-modify-write.
- R8: A request whose address lies outside both windows is forwarded as a single unlocked target transaction. The address, direction and write data are unchanged, and the target read data is returned unchanged. This also holds for addresses one word below or at the first address above a window.
- R9: The RAM window and the peripheral window decode independently. Each one maps only onto its own target region, using its own bases and span; a window covers 32 times its target span.
- R10: After reset, t_valid, t_lock and m_ready are low until the master raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_valid | input | 1 | Master request valid, held until m_ready |
| m_ready | output | 1 | Master request complete (one cycle) |
| m_write | input | 1 | Master request is a write |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Master read data, valid with m_ready on reads |
| t_valid | output | 1 | Target request valid |
| t_ready | input | 1 | Target accepts the request this cycle |
| t_write | output | 1 | Target request is a write |
| t_addr | output | 32 | Target byte address |
| t_wdata | output | 32 | Target write data |
| t_rdata | input | 32 | Target read data, valid with t_ready |
| t_lock | output | 1 | Target word locked for a read-modify-write |

## Verification
A wrong captured bit index or word address shows up on the target port in the same cycle as the request. It appears as a read of the wrong word, or, one transaction later, as a write that changes a neighbouring bit. A comparison of the whole target memory against a shadow copy after every alias write catches either case before the next request. A sequencer stuck in the wrong phase shows up as a missing or duplicated m_ready, a second target handshake where there should be one, or t_lock falling between the read and the write. These faults are visible within one transaction, and the bound properties flag them in the cycle they occur.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_DW        = 32;
    localparam int BB_IDX_W     = $clog2(BB_DW);
    localparam int BB_EXPAND_L2 = $clog2(BB_DW);   // alias bytes per target byte, log2
    localparam int BB_WORD_L2   = 2;               // byte offset bits inside a word

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PASS,
        ST_FETCH,
        ST_STORE
    } bb_state_e;

    typedef struct packed {
        logic                 hit;
        logic [BB_DW-1:0]     word_addr;
        logic [BB_IDX_W-1:0]  bit_idx;
    } bb_hit_t;

    typedef struct packed {
        logic                 write;
        logic                 is_bb;
        logic [BB_DW-1:0]     addr;
        logic [BB_IDX_W-1:0]  bit_idx;
        logic [BB_DW-1:0]     wdata;
    } bb_req_t;

    function automatic logic [BB_DW-1:0] bb_merge(input logic [BB_DW-1:0] word,
                                                 input logic [BB_IDX_W-1:0] idx,
                                                 input logic val);
        logic [BB_DW-1:0] sel;
        sel = {{(BB_DW-1){1'b0}}, 1'b1} << idx;
        return val ? (word | sel) : (word & ~sel);
    endfunction

    function automatic logic [BB_DW-1:0] bb_extract(input logic [BB_DW-1:0] word,
                                                   input logic [BB_IDX_W-1:0] idx);
        return {{(BB_DW-1){1'b0}}, word[idx]};
    endfunction

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
    import bb_pkg::*;
#(
    parameter logic [31:0] TGT_BASE   = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
    parameter int          SPAN_L2    = 20
) (
    input  logic [BB_DW-1:0] addr,
    output bb_hit_t          hit
);
    // Window covers 2**(SPAN_L2+5) alias bytes.
    localparam int WIN_L2 = SPAN_L2 + BB_EXPAND_L2;
    localparam int LO     = BB_EXPAND_L2 + BB_WORD_L2;   // first word-number bit

    logic [BB_DW-1:0] off;

    assign off = addr - ALIAS_BASE;

    always_comb begin
        hit.hit       = (off >> WIN_L2) == '0;
        hit.word_addr = TGT_BASE + {{(BB_EXPAND_L2){1'b0}}, off[BB_DW-1:LO], {BB_WORD_L2{1'b0}}};
        hit.bit_idx   = off[LO-1:BB_WORD_L2];
    end

endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
    import bb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             m_valid,
    input  bb_req_t          req_in,
    output logic             m_ready,
    output logic [BB_DW-1:0] m_rdata,
    output logic             t_valid,
    input  logic             t_ready,
    output logic             t_write,
    output logic [BB_DW-1:0] t_addr,
    output logic [BB_DW-1:0] t_wdata,
    input  logic [BB_DW-1:0] t_rdata,
    output logic             t_lock
);
    bb_state_e        st_q;
    bb_req_t          cap_q;
    logic [BB_DW-1:0] fetched_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cap_q     <= '0;
            fetched_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (m_valid) begin
                        cap_q <= req_in;
                        st_q  <= req_in.is_bb ? ST_FETCH : ST_PASS;
                    end
                end
                ST_PASS: begin
                    if (t_ready) st_q <= ST_IDLE;
                end
                ST_FETCH: begin
                    if (t_ready) begin
                        if (cap_q.write) begin
                            fetched_q <= t_rdata;
                            st_q      <= ST_STORE;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_STORE: begin
                    if (t_ready) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        m_ready = 1'b0;
        m_rdata = '0;
        t_valid = 1'b0;
        t_write = 1'b0;
        t_addr  = cap_q.addr;
        t_wdata = '0;
        t_lock  = 1'b0;
        case (st_q)
            ST_PASS: begin
                t_valid = 1'b1;
                t_write = cap_q.write;
                t_wdata = cap_q.wdata;
                m_ready = t_ready;
                m_rdata = t_ready ? t_rdata : '0;
            end
            ST_FETCH: begin
                t_valid = 1'b1;
                t_lock  = cap_q.write;
                if (!cap_q.write) begin
                    m_ready = t_ready;
                    m_rdata = t_ready ? bb_extract(t_rdata, cap_q.bit_idx) : '0;
                end
            end
            ST_STORE: begin
                t_valid = 1'b1;
                t_write = 1'b1;
                t_lock  = 1'b1;
                t_wdata = bb_merge(fetched_q, cap_q.bit_idx, cap_q.wdata[0]);
                m_ready = t_ready;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter logic [31:0] RAM_BASE       = 32'h2000_0000,
    parameter logic [31:0] RAM_ALIAS_BASE = 32'h2200_0000,
    parameter int          RAM_SPAN_L2    = 20,
    parameter logic [31:0] PER_BASE       = 32'h4000_0000,
    parameter logic [31:0] PER_ALIAS_BASE = 32'h4200_0000,
    parameter int          PER_SPAN_L2    = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        m_valid,
    output logic        m_ready,
    input  logic        m_write,
    input  logic [31:0] m_addr,
    input  logic [31:0] m_wdata,
    output logic [31:0] m_rdata,
    output logic        t_valid,
    input  logic        t_ready,
    output logic        t_write,
    output logic [31:0] t_addr,
    output logic [31:0] t_wdata,
    input  logic [31:0] t_rdata,
    output logic        t_lock
);
    localparam int NWIN = 2;   // index 0: RAM window, index 1: peripheral window

    bb_hit_t hits [NWIN];
    bb_req_t req;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        bb_window_decode #(
            .TGT_BASE   (g == 0 ? RAM_BASE       : PER_BASE),
            .ALIAS_BASE (g == 0 ? RAM_ALIAS_BASE : PER_ALIAS_BASE),
            .SPAN_L2    (g == 0 ? RAM_SPAN_L2    : PER_SPAN_L2)
        ) u_dec (
            .addr (m_addr),
            .hit  (hits[g])
        );
    end

    // Lowest window index wins if windows were ever configured to overlap.
    always_comb begin
        req.write   = m_write;
        req.wdata   = m_wdata;
        req.is_bb   = 1'b0;
        req.addr    = m_addr;
        req.bit_idx = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i].hit) begin
                req.is_bb   = 1'b1;
                req.addr    = hits[i].word_addr;
                req.bit_idx = hits[i].bit_idx;
            end
        end
    end

    bb_rmw_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .m_valid (m_valid),
        .req_in  (req),
        .m_ready (m_ready),
        .m_rdata (m_rdata),
        .t_valid (t_valid),
        .t_ready (t_ready),
        .t_write (t_write),
        .t_addr  (t_addr),
        .t_wdata (t_wdata),
        .t_rdata (t_rdata),
        .t_lock  (t_lock)
    );

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        m_valid,
    input logic        m_ready,
    input logic        t_valid,
    input logic        t_ready,
    input logic        t_write,
    input logic        t_lock,
    input logic [31:0] t_addr
);
    logic rd_locked_hs;
    logic wr_locked_hs;

    assign rd_locked_hs = t_valid && t_ready && !t_write && t_lock;
    assign wr_locked_hs = t_valid && t_ready && t_write && t_lock;

    AST_LOCKED_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        rd_locked_hs |=> (t_valid && t_write && t_lock && t_addr == $past(t_addr))); // R5

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (t_lock && !wr_locked_hs) |=> t_lock); // R6

    AST_LOCK_RELEASED: assert property (@(posedge clk) disable iff (rst)
        wr_locked_hs |=> !t_lock); // R6

    AST_LOCK_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        t_lock |-> t_valid); // R6

    AST_READY_ON_TARGET_HS: assert property (@(posedge clk) disable iff (rst)
        m_ready |-> (m_valid && t_valid && t_ready)); // R7

    AST_NO_READY_MID_RMW: assert property (@(posedge clk) disable iff (rst)
        rd_locked_hs |-> !m_ready); // R7

    AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!t_valid && !m_ready && !t_lock)); // R10

endmodule

bind bitband_bridge bitband_bridge_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .t_valid (t_valid),
    .t_ready (t_ready),
    .t_write (t_write),
    .t_lock  (t_lock),
    .t_addr  (t_addr)
);

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;

    // Small map: RAM words 0x000..0x03C, peripheral words 0x100..0x11C
    localparam logic [31:0] RB = 32'h0000_0000, RA = 32'h0000_1000;
    localparam logic [31:0] PB = 32'h0000_0100, PA = 32'h0000_2000;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic        rst, m_valid, m_ready, m_write;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic        t_valid, t_ready, t_write, t_lock;
    logic [31:0] t_addr, t_wdata, t_rdata;

    bitband_bridge #(
        .RAM_BASE(RB), .RAM_ALIAS_BASE(RA), .RAM_SPAN_L2(6),
        .PER_BASE(PB), .PER_ALIAS_BASE(PA), .PER_SPAN_L2(5)
    ) u0 (.*);

    // Target model with pseudo-random stalls
    logic [31:0] mem    [128];
    logic [31:0] shadow [128];
    logic [7:0]  lf;
    assign t_ready = t_valid && (lf[0] || lf[2]);
    assign t_rdata = mem[t_addr[8:2]];
    always @(posedge clk) begin
        if (rst) lf <= 8'h5B;
        else     lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (t_valid && t_ready && t_write) mem[t_addr[8:2]] <= t_wdata;
    end

    // Handshake monitor
    int          hs_cnt = 0, rdy_cnt = 0;
    logic [31:0] hs_addr [4];
    logic        hs_wr [4], hs_lk [4];
    always @(posedge clk) begin
        if (!rst) begin
            if (t_valid && t_ready) begin
                hs_addr[hs_cnt & 3] <= t_addr;
                hs_wr[hs_cnt & 3]   <= t_write;
                hs_lk[hs_cnt & 3]   <= t_lock;
                hs_cnt              <= hs_cnt + 1;
            end
            if (m_valid && m_ready) rdy_cnt <= rdy_cnt + 1;
        end
    end

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int mem_mismatch();
        for (int i = 0; i < 128; i++) if (mem[i] !== shadow[i]) return i;
        return -1;
    endfunction

    task automatic acc(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int nhs, output int nrdy, output int h0);
        int r0;
        @(negedge clk);
        m_valid = 1'b1; m_write = wr; m_addr = a; m_wdata = wd;
        h0 = hs_cnt; r0 = rdy_cnt;
        do @(negedge clk); while (!m_ready);
        rd = m_rdata;
        @(posedge clk); #1;
        m_valid = 1'b0;
        nhs = hs_cnt - h0; nrdy = rdy_cnt - r0;
    endtask

    task automatic pass_check(input logic wr, input logic [31:0] a, input logic [31:0] wd);
        logic [31:0] rd, exp;
        int nhs, nrdy, h0;
        exp = mem[a[8:2]];
        acc(wr, a, wd, rd, nhs, nrdy, h0);
        chk(nhs == 1 && nrdy == 1, "R8 single transaction", nhs, 1);
        chk(hs_addr[h0 & 3] == a && hs_wr[h0 & 3] == wr && !hs_lk[h0 & 3], "R8 unchanged addr/dir", hs_addr[h0 & 3], a);
        if (wr) begin
            shadow[a[8:2]] = wd;
            chk(mem[a[8:2]] == wd, "R8 write data forwarded", mem[a[8:2]], wd);
        end else begin
            chk(rd == exp, "R8 read data returned", rd, exp);
        end
    endtask

    task automatic alias_sweep_read(input string tag);
        logic [31:0] rd, exp;
        int nhs, nrdy, h0;
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < (r == 0 ? 16 : 8); w++) begin
                for (int b = 0; b < 32; b++) begin
                    int idx;
                    idx = (r == 0 ? 0 : 64) + w;
                    acc(1'b0, (r == 0 ? RA : PA) + 32'(w * 128 + b * 4 + (b % 4)), 32'hFFFF_FFFF, rd, nhs, nrdy, h0);
                    exp = {31'd0, shadow[idx][b]};
                    chk(rd == exp, {tag, " R2 alias read bit"}, rd, exp);
                    chk(nhs == 1 && nrdy == 1 && !hs_wr[h0 & 3] && !hs_lk[h0 & 3], "R2 one unlocked read", nhs, 1);
                    chk(hs_addr[h0 & 3] == 32'(idx * 4), "R1 R9 mapped word", hs_addr[h0 & 3], 32'(idx * 4));
                end
            end
        end
    endtask

    initial begin
        logic [31:0] rd, wd;
        int nhs, nrdy, h0, mm;
        rst = 1'b1; m_valid = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0;
        for (int i = 0; i < 128; i++) begin
            mem[i]    = 32'(i) * 32'h9E37_79B9 ^ 32'h5A5A_0F0F;
            shadow[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!t_valid && !t_lock && !m_ready, "R10 idle after reset", {29'd0, t_valid, t_lock, m_ready}, 0);

        // Pass-through, including addresses bordering the windows
        for (int i = 0; i < 16; i++) pass_check(1'b0, 32'(i * 4), '0);
        for (int i = 64; i < 72; i++) pass_check(1'b0, 32'(i * 4), '0);
        pass_check(1'b1, 32'h0000_0040, 32'hCAFE_F00D);
        pass_check(1'b0, RA - 4, '0);
        pass_check(1'b0, RA + 32'h800, '0);
        pass_check(1'b0, PA - 4, '0);
        pass_check(1'b0, PA + 32'h400, '0);
        pass_check(1'b1, PA + 32'h400, 32'h1234_5678);
        chk(mem_mismatch() < 0, "R8 memory after pass writes", mem_mismatch(), -1);

        alias_sweep_read("initial");

        // Exhaustive alias writes with garbage in the upper data bits
        for (int r = 0; r < 2; r++) begin
            for (int w = 0; w < (r == 0 ? 16 : 8); w++) begin
                for (int b = 0; b < 32; b++) begin
                    int idx;
                    logic v;
                    idx = (r == 0 ? 0 : 64) + w;
                    v   = ((w + b) % 3 != 0) ? ~shadow[idx][b] : shadow[idx][b];
                    wd  = v ? 32'h0000_0001 : 32'hFFFF_FFFE;
                    acc(1'b1, (r == 0 ? RA : PA) + 32'(w * 128 + b * 4), wd, rd, nhs, nrdy, h0);
                    shadow[idx][b] = v;
                    mm = mem_mismatch();
                    chk(mm < 0, "R3 R4 memory vs shadow", (mm < 0) ? 0 : mem[mm], (mm < 0) ? 0 : shadow[mm]);
                    chk(nhs == 2 && nrdy == 1, "R5 R7 two target handshakes, one ready", nhs, 2);
                    chk(!hs_wr[h0 & 3] && hs_wr[(h0 + 1) & 3] && hs_lk[h0 & 3] && hs_lk[(h0 + 1) & 3],
                        "R5 R6 locked read then locked write", {hs_wr[h0 & 3], hs_wr[(h0 + 1) & 3]}, 32'h1);
                    chk(hs_addr[h0 & 3] == 32'(idx * 4) && hs_addr[(h0 + 1) & 3] == 32'(idx * 4),
                        "R1 R5 same mapped word", hs_addr[(h0 + 1) & 3], 32'(idx * 4));
                    chk(!t_lock && !t_valid, "R6 lock released after write", {31'd0, t_lock}, 0);
                end
            end
        end

        alias_sweep_read("final");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=done", 200000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule